// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level page table from memory. A table-base register names the physical location of the active top-level table. Software reloads this register to change address spaces. A request carries a virtual address, an access kind and a privilege flag. For each request the walker reads at most two 32-bit entries through a memory read port. It then returns one response: either a physical address, or a fault with a cause code. The response always carries the virtual address that was translated.

The address is cut into three fields. The upper ten bits [31:22] select a first-level entry. The middle ten bits [21:12] select a second-level entry. The low twelve bits [11:0] are the byte offset inside a 4 KB page. Entries are 32 bits wide. In every entry, bits [31:12] give a 4 KB-aligned base, which is either the next table or the page frame. The flag bits are: bit 0 valid, bit 1 read allowed, bit 2 write allowed, bit 3 execute allowed, and bit 4 user access allowed. A first-level entry uses only bit 0 and bits [31:12].

All three data paths are valid/ready streams. A transfer happens on a clock edge where both valid and ready are high. Once the walker raises a valid, it holds it and keeps its payload unchanged until ready is seen. It accepts a new request only when idle. The memory may stall the address channel for any number of cycles. The consumer may hold off the response for any number of cycles. While a walk or an unconsumed response exists, the walker keeps `req_ready` low.

Top module: `pt_walker`

## Requirements
- R1: `req_ready` is high only when no walk is in progress and no response is pending. At reset it is high, and `rsp_valid` and `mem_req_valid` are low. An accepted request captures the virtual address, the access kind and the privilege flag. The access kind is encoded 00 read, 01 write, 10 execute. The privilege flag is 1 for kernel and 0 for user.
- R2: In the cycle after a request is accepted, the walker presents the first-level read. Its address is base + VA[31:22]*4. A read address stays valid and unchanged until `mem_req_ready` is seen.
- R3: If bit 0 of the first-level entry is clear, the walk ends with fault cause 0. No second read is issued.
- R4: The second-level read address is {L1[31:12], 12'h000} + VA[21:12]*4.
- R5: If bit 0 of the second-level entry is clear, the walk ends with fault cause 1.
- R6: A user-mode access to a second-level entry whose bit 4 is clear faults with cause 3. In kernel mode, bit 4 is ignored.
- R7: An access kind that the second-level entry does not grant faults with cause 2. Reads need bit 1, writes need bit 2 and executes need bit 3. Access kind code 11 is granted by no entry. When both cause 3 and cause 2 apply, cause 3 is reported.
- R8: A walk that does not fault returns `rsp_fault` low and `rsp_paddr` = {L2[31:12], VA[11:0]}. A faulting walk returns `rsp_paddr` zero.
- R9: While `rsp_valid` is high and `rsp_ready` is low, every response field holds its value. `rsp_vaddr` equals the accepted virtual address.
- R10: The base register resets to zero. A write takes effect for the next accepted request. A write during a walk, or in the same cycle a request is accepted, does not change the walk that is already under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_wr_en | input | 1 | Load the table-base register |
| base_wr_data | input | 32 | New top-level table physical address |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker can accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_acc | input | 2 | Access kind: 00 read, 01 write, 10 execute |
| req_kernel | input | 1 | 1 kernel mode, 0 user mode |
| mem_req_valid | output | 1 | Entry read address valid |
| mem_req_ready | input | 1 | Memory takes the read address |
| mem_req_addr | output | 32 | Physical address of the entry to read |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_ready | output | 1 | Walker is waiting for entry data |
| mem_rsp_data | input | 32 | Entry read from memory |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_fault | output | 1 | Walk ended in a page fault |
| rsp_cause | output | 2 | Fault cause: 0 L1 absent, 1 L2 absent, 2 permission, 3 privilege |
| rsp_paddr | output | 32 | Physical address, zero on a fault |
| rsp_vaddr | output | 32 | Virtual address that was translated |

## Verification
The assertions assume that the memory returns entry data only after a read address has been accepted, one beat per read, and only while `mem_rsp_ready` is high. They also assume that software writes only word-aligned table bases, and that `rst_n` is low for the first edges.

The bench memory model follows these rules. It answers each accepted read exactly once, in the following cycle. It can withhold `mem_req_ready` for a set number of cycles. All table bases it uses are 4 KB aligned. The bench raises requests only while `req_ready` is high. It changes `rsp_ready` only at falling edges.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  // byte shift from entry index to entry address (4-byte entries)
  localparam int unsigned ENT_SHIFT = 2;

  // flag positions inside an entry
  localparam int unsigned BIT_V  = 0;
  localparam int unsigned BIT_R  = 1;
  localparam int unsigned BIT_WR = 2;
  localparam int unsigned BIT_X  = 3;
  localparam int unsigned BIT_U  = 4;
  localparam int unsigned FLAG_W = 5;

  localparam logic [1:0] ACC_READ  = 2'd0;
  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_EXEC  = 2'd2;

  localparam logic [1:0] CAUSE_L1   = 2'd0;
  localparam logic [1:0] CAUSE_L2   = 2'd1;
  localparam logic [1:0] CAUSE_PERM = 2'd2;
  localparam logic [1:0] CAUSE_PRIV = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_L1_ADDR,
    ST_L1_DATA,
    ST_L2_ADDR,
    ST_L2_DATA,
    ST_DONE
  } walk_st_e;
endpackage

// File: rtl/pt_base_reg.sv
module pt_base_reg #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_data,
  output logic [ADDR_W-1:0] base_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     base_q <= '0;
    else if (wr_en) base_q <= wr_data;
  end
endmodule

// File: rtl/pt_entry_check.sv
module pt_entry_check
  import pt_walker_pkg::*;
(
  input  logic [FLAG_W-1:0] flags,
  input  logic [1:0]        acc,
  input  logic              kernel,
  output logic              fault,
  output logic [1:0]        cause
);
  logic grant;

  always_comb begin
    unique case (acc)
      ACC_READ:  grant = flags[BIT_R];
      ACC_WRITE: grant = flags[BIT_WR];
      ACC_EXEC:  grant = flags[BIT_X];
      default:   grant = 1'b0;
    endcase
  end

  // absent, then privilege, then access kind
  always_comb begin
    fault = 1'b1;
    cause = CAUSE_L1;
    if (!flags[BIT_V])                 cause = CAUSE_L2;
    else if (!kernel && !flags[BIT_U]) cause = CAUSE_PRIV;
    else if (!grant)                   cause = CAUSE_PERM;
    else                               fault = 1'b0;
  end
endmodule

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl
  import pt_walker_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 12,
  parameter int unsigned IDX_W  = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       base_q,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ADDR_W-1:0]       req_vaddr,
  input  logic [1:0]              req_acc,
  input  logic                    req_kernel,
  output logic                    mem_req_valid,
  input  logic                    mem_req_ready,
  output logic [ADDR_W-1:0]       mem_req_addr,
  input  logic                    mem_rsp_valid,
  output logic                    mem_rsp_ready,
  input  logic [ADDR_W-OFF_W-1:0] ent_frame,
  input  logic                    ent_valid,
  input  logic                    chk_fault,
  input  logic [1:0]              chk_cause,
  output logic [1:0]              acc_q,
  output logic                    kern_q,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic                    rsp_fault,
  output logic [1:0]              rsp_cause,
  output logic [ADDR_W-1:0]       rsp_paddr,
  output logic [ADDR_W-1:0]       rsp_vaddr
);
  walk_st_e          st;
  logic [ADDR_W-1:0] va_q;
  logic [ADDR_W-1:0] tbl_q;
  logic [IDX_W-1:0]  idx_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      va_q      <= '0;
      tbl_q     <= '0;
      acc_q     <= ACC_READ;
      kern_q    <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_cause <= CAUSE_L1;
      rsp_paddr <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (req_valid) begin
          va_q   <= req_vaddr;
          acc_q  <= req_acc;
          kern_q <= req_kernel;
          tbl_q  <= base_q;
          st     <= ST_L1_ADDR;
        end
        ST_L1_ADDR: if (mem_req_ready) st <= ST_L1_DATA;
        ST_L1_DATA: if (mem_rsp_valid) begin
          if (!ent_valid) begin
            rsp_fault <= 1'b1;
            rsp_cause <= CAUSE_L1;
            rsp_paddr <= '0;
            st        <= ST_DONE;
          end else begin
            tbl_q <= {ent_frame, {OFF_W{1'b0}}};
            st    <= ST_L2_ADDR;
          end
        end
        ST_L2_ADDR: if (mem_req_ready) st <= ST_L2_DATA;
        ST_L2_DATA: if (mem_rsp_valid) begin
          rsp_fault <= chk_fault;
          rsp_cause <= chk_cause;
          rsp_paddr <= chk_fault ? '0 : {ent_frame, va_q[OFF_W-1:0]};
          st        <= ST_DONE;
        end
        ST_DONE: if (rsp_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    idx_sel       = (st == ST_L1_ADDR) ? va_q[ADDR_W-1 -: IDX_W] : va_q[OFF_W +: IDX_W];
    mem_req_addr  = tbl_q + (ADDR_W'(idx_sel) << ENT_SHIFT);
    mem_req_valid = (st == ST_L1_ADDR) || (st == ST_L2_ADDR);
    mem_rsp_ready = (st == ST_L1_DATA) || (st == ST_L2_DATA);
    req_ready     = (st == ST_IDLE);
    rsp_valid     = (st == ST_DONE);
    rsp_vaddr     = va_q;
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 12,
  parameter int unsigned IDX_W  = (ADDR_W - OFF_W) / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_wr_en,
  input  logic [ADDR_W-1:0] base_wr_data,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic [1:0]        req_acc,
  input  logic              req_kernel,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_fault,
  output logic [1:0]        rsp_cause,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic [ADDR_W-1:0] rsp_vaddr
);
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        acc_q;
  logic              kern_q;
  logic              chk_fault;
  logic [1:0]        chk_cause;

  pt_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (base_wr_en),
    .wr_data (base_wr_data),
    .base_q  (base_q)
  );

  pt_entry_check u_check (
    .flags  (mem_rsp_data[FLAG_W-1:0]),
    .acc    (acc_q),
    .kernel (kern_q),
    .fault  (chk_fault),
    .cause  (chk_cause)
  );

  pt_walk_ctrl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .base_q        (base_q),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .req_acc       (req_acc),
    .req_kernel    (req_kernel),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_ready (mem_rsp_ready),
    .ent_frame     (mem_rsp_data[ADDR_W-1:OFF_W]),
    .ent_valid     (mem_rsp_data[BIT_V]),
    .chk_fault     (chk_fault),
    .chk_cause     (chk_cause),
    .acc_q         (acc_q),
    .kern_q        (kern_q),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_fault     (rsp_fault),
    .rsp_cause     (rsp_cause),
    .rsp_paddr     (rsp_paddr),
    .rsp_vaddr     (rsp_vaddr)
  );
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rsp_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_fault,
  input logic [1:0]        rsp_cause,
  input logic [ADDR_W-1:0] rsp_paddr,
  input logic [ADDR_W-1:0] rsp_vaddr
);
  // R1
  one_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || mem_req_valid || mem_rsp_ready) |-> !req_ready);

  // R2
  first_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (mem_req_valid && !rsp_valid));

  // R2
  mem_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R2
  read_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req_valid && mem_rsp_ready));

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_fault) && $stable(rsp_cause)
                                   && $stable(rsp_paddr) && $stable(rsp_vaddr)));

  // R8
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_paddr[OFF_W-1:0] == rsp_vaddr[OFF_W-1:0]));

  // R8
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));
endmodule

bind pt_walker pt_walker_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (.*);

// File: tb/test_pt_walker.sv
`timescale 1ns/1ps
module test_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_wr_en = 1'b0;
  logic [31:0] base_wr_data = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_acc = '0;
  logic        req_kernel = 1'b0;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic        mem_rsp_ready;
  logic [31:0] mem_rsp_data;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic        rsp_fault;
  logic [1:0]  rsp_cause;
  logic [31:0] rsp_paddr;
  logic [31:0] rsp_vaddr;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pt_walker i_pt_walker (.*);

  // memory model
  logic [31:0] mem_model [logic [31:0]];
  int          stall_cfg = 0;
  int          rd_total = 0;
  logic [31:0] prev_addr = '0;
  logic [31:0] cur_addr = '0;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem_model.exists(a) ? mem_model[a] : 32'h0;
  endfunction

  initial begin
    bit          pend = 0;
    logic [31:0] pend_addr = '0;
    int          waited = 0;
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (pend) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = rd(pend_addr);
        pend = 0;
      end
      if (mem_req_valid && waited < stall_cfg) begin
        mem_req_ready = 1'b0;
        waited++;
      end else begin
        mem_req_ready = 1'b1;
        if (mem_req_valid) begin
          pend = 1;
          pend_addr = mem_req_addr;
          prev_addr = cur_addr;
          cur_addr  = mem_req_addr;
          rd_total++;
          waited = 0;
        end
      end
    end
  end

  localparam logic [31:0] BASE_A = 32'h0010_0000;
  localparam logic [31:0] BASE_B = 32'h0020_0000;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic        got_fault;
  logic [1:0]  got_cause;
  logic [31:0] got_pa, got_va;
  int          got_reads;
  bit          hold_ok;

  task automatic walk(input logic [31:0] va, input logic [1:0] acc, input bit kern, input int hold);
    int rd0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    rd0 = rd_total;
    req_valid = 1'b1; req_vaddr = va; req_acc = acc; req_kernel = kern;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    got_fault = rsp_fault; got_cause = rsp_cause; got_pa = rsp_paddr; got_va = rsp_vaddr;
    hold_ok = 1;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      if (!rsp_valid || req_ready || rsp_fault !== got_fault || rsp_cause !== got_cause ||
          rsp_paddr !== got_pa || rsp_vaddr !== got_va) hold_ok = 0;
    end
    got_reads = rd_total - rd0;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic expect_ok(input string tag, input logic [31:0] pa);
    check(tag, {31'd0, got_fault}, 32'd0);
    check(tag, got_pa, pa);
  endtask

  task automatic expect_fault(input string tag, input logic [1:0] cause);
    check(tag, {31'd0, got_fault}, 32'd1);
    check(tag, {30'd0, got_cause}, {30'd0, cause});
    check(tag, got_pa, 32'd0);
  endtask

  task automatic set_base(input logic [31:0] b);
    @(negedge clk);
    base_wr_en = 1'b1; base_wr_data = b;
    @(negedge clk);
    base_wr_en = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 reset req_ready", {31'd0, req_ready}, 32'd1);
    check("R1 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
    check("R1 reset mem_req_valid", {31'd0, mem_req_valid}, 32'd0);
  endtask

  task automatic t_basic();
    walk(32'h0000_0010, 2'd0, 1'b1, 0);
    expect_ok("R8 kernel read page0", 32'h4000_0010);
    check("R2 L1 address", prev_addr, BASE_A);
    check("R4 L2 address", cur_addr, 32'h0030_0000);
    check("R9 vaddr echo", got_va, 32'h0000_0010);
    walk(32'h0000_1234, 2'd0, 1'b0, 0);
    expect_ok("R8 user read RX page", 32'h0060_0234);
    check("R4 L2 address idx1", cur_addr, 32'h0030_0004);
    walk(32'h0000_1FF0, 2'd2, 1'b0, 0);
    expect_ok("R7 exec RX page", 32'h0060_0FF0);
    walk(32'h0000_1008, 2'd1, 1'b0, 0);
    expect_fault("R7 write RX page", 2'd2);
    walk(32'h0000_2010, 2'd2, 1'b0, 0);
    expect_fault("R7 exec RW page", 2'd2);
    walk(32'h0000_2010, 2'd1, 1'b0, 0);
    expect_ok("R7 write RW page", 32'h0080_0010);
    walk(32'h0000_0010, 2'd3, 1'b1, 0);
    expect_fault("R7 reserved access kind", 2'd2);
  endtask

  task automatic t_absent();
    walk(32'h0040_0123, 2'd0, 1'b1, 0);
    expect_fault("R3 L1 absent", 2'd0);
    check("R3 single read", got_reads, 1);
    check("R2 L1 address idx1", cur_addr, BASE_A + 32'd4);
    walk(32'h0000_3010, 2'd0, 1'b1, 0);
    expect_fault("R5 L2 absent", 2'd1);
    check("R5 two reads", got_reads, 2);
  endtask

  task automatic t_priv();
    walk(32'hC000_0ABC, 2'd0, 1'b0, 0);
    expect_fault("R6 user on kernel page", 2'd3);
    check("R2 L1 address idx768", prev_addr, BASE_A + 32'h0000_0C00);
    walk(32'hC000_0ABC, 2'd0, 1'b1, 0);
    expect_ok("R6 kernel on kernel page", 32'h0000_0ABC);
    walk(32'hC000_1004, 2'd1, 1'b0, 0);
    expect_fault("R7 privilege before permission", 2'd3);
    walk(32'hC000_1004, 2'd1, 1'b1, 0);
    expect_fault("R7 kernel write read-only", 2'd2);
  endtask

  task automatic t_backpressure();
    stall_cfg = 3;
    walk(32'h0000_1444, 2'd0, 1'b0, 5);
    expect_ok("R2 stalled memory", 32'h0060_0444);
    check("R9 response held, R1 no accept", {31'd0, hold_ok}, 32'd1);
    walk(32'h0040_0000, 2'd0, 1'b0, 4);
    expect_fault("R3 stalled L1 absent", 2'd0);
    check("R9 fault held", {31'd0, hold_ok}, 32'd1);
    stall_cfg = 0;
  endtask

  task automatic t_base_switch();
    stall_cfg = 4;
    fork
      walk(32'h0000_0020, 2'd0, 1'b1, 0);
      begin
        repeat (3) @(negedge clk);
        base_wr_en = 1'b1; base_wr_data = BASE_B;
        @(negedge clk);
        base_wr_en = 1'b0;
      end
    join
    expect_ok("R10 write during walk ignored", 32'h4000_0020);
    stall_cfg = 0;
    walk(32'h0000_0020, 2'd0, 1'b1, 0);
    expect_ok("R10 next walk uses new base", 32'h7000_0020);
    check("R10 L1 address new base", prev_addr, BASE_B);
    set_base(BASE_A);
  endtask

  initial begin
    mem_model[BASE_A + 32'h000]      = 32'h0030_0001;
    mem_model[32'h0030_0000]         = 32'h4000_001F;
    mem_model[32'h0030_0004]         = 32'h0060_001B;
    mem_model[32'h0030_0008]         = 32'h0080_0017;
    mem_model[BASE_A + 32'hC00]      = 32'h0031_0001;
    mem_model[32'h0031_0000]         = 32'h0000_000F;
    mem_model[32'h0031_0004]         = 32'h0001_0003;
    mem_model[BASE_B + 32'h000]      = 32'h0032_0001;
    mem_model[32'h0032_0000]         = 32'h7000_001F;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    set_base(BASE_A);
    t_basic();
    t_absent();
    t_priv();
    t_backpressure();
    t_base_switch();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule